// File: doc/BRIEF.md
# Receive Destination Address Filter

This block judges each incoming Ethernet frame by its 48-bit destination address. It sorts the address into broadcast, multicast or unicast, then decides from a control word whether frames of that kind are kept. A header is presented for one cycle on `hdr_valid`/`hdr_dst`. One cycle later the block returns a one-cycle verdict carrying an accept flag and a 2-bit destination class.

Configuration arrives through a single write port with three targets. The first is a pointer into a small filter RAM. The second is a data register that writes the 16-bit filter word the pointer selects. The third is the control word. The station address occupies three 16-bit words at even pointer offsets. Each word holds two address bytes, with the lower-numbered byte in the low half. The control word carries a master enable and four accept enables. While the master enable is set, the four accept enables are locked against change.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `res_valid` and `res_accept` are 0, the control word is all zero and the station words are zero, so every frame is rejected until software configures the block.
- R2: For every cycle with `hdr_valid` high, `res_valid` is high for exactly one cycle on the next clock edge. `res_valid` is low otherwise.
- R3: A destination of all ones is reported with class 2'b11 (broadcast).
- R4: A destination that is not all ones and has bit 0 of byte 0 set (`hdr_dst[0]`) is reported as class 2'b10 (multicast). Every other destination is class 2'b01 (unicast). Class 2'b00 is never reported.
- R5: While control bit 31 (master enable) is 0, every frame is rejected.
- R6: With the master enable set, the three accept-all enables each admit their own class. Control bit 30 admits broadcast, bit 29 admits multicast and bit 28 admits unicast.
- R7: With the master enable set and control bit 27 (perfect match) set, a unicast frame whose six bytes all equal the stored station address is accepted. A unicast frame that differs in any byte is rejected unless bit 28 is set.
- R8: `cfg_sel` selects the write target: 2'b00 loads the pointer, 2'b01 writes `cfg_wdata[15:0]` to the filter word the pointer selects, and 2'b10 writes the control word. Pointer offsets 0, 2 and 4 hold station bytes 0-1, 2-3 and 4-5, with byte 2k in bits 7:0 and byte 2k+1 in bits 15:8. Address byte i sits at `hdr_dst[8i+7:8i]`. Data writes at any other offset change nothing, and `cfg_sel` 2'b11 is ignored.
- R9: A control-word write made while the stored master enable is 1 updates only the master enable. Bits 30 to 27 keep their previous values.
- R10: When a configuration write and a header fall in the same cycle, the header is judged with the settings that held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: pointer, filter data, control word |
| cfg_wdata | input | 32 | Write data |
| hdr_valid | input | 1 | Destination address present this cycle |
| hdr_dst | input | 48 | Destination address, byte i at bits 8i+7:8i |
| res_valid | output | 1 | Verdict valid, one cycle after the header |
| res_accept | output | 1 | Frame accepted |
| res_class | output | 2 | 01 unicast, 10 multicast, 11 broadcast |

## Verification
Two functions can act in the same cycle: a configuration write and the judging of a header. The bench provokes this by driving a control-word write, or a station-word write, on the same clock edge as a header whose verdict would flip under the new setting. It judges the result by checking that the verdict reflects the old setting. It then checks that the next header reflects the new one. A scoreboard model applies each write only after computing the verdict for a header in that cycle, so any forwarding of the new setting shows up as a mismatch.

// File: rtl/raf_pkg.sv
package raf_pkg;
   typedef enum logic [1:0] {
      DCLS_RSVD  = 2'b00,
      DCLS_UNI   = 2'b01,
      DCLS_MULTI = 2'b10,
      DCLS_BCAST = 2'b11
   } dcls_e;

   typedef enum logic [1:0] {
      SEL_PTR  = 2'b00,
      SEL_DATA = 2'b01,
      SEL_CTRL = 2'b10,
      SEL_NONE = 2'b11
   } sel_e;

   localparam int CTRL_EN_BIT = 31;
   localparam int CTRL_BC_BIT = 30;
   localparam int CTRL_MC_BIT = 29;
   localparam int CTRL_UC_BIT = 28;
   localparam int CTRL_PM_BIT = 27;

   typedef struct packed {
      logic en;
      logic all_bc;
      logic all_mc;
      logic all_uc;
      logic perfect;
   } ctrl_t;
endpackage

// File: rtl/raf_cfg_regs.sv
module raf_cfg_regs
   import raf_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int PTR_W      = 8,
   parameter int REG_W      = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [1:0]              wr_sel,
   input  logic [REG_W-1:0]        wr_data,
   output logic [ADDR_BYTES*8-1:0] station,
   output ctrl_t                   ctrl
);
   localparam int WORDS = ADDR_BYTES / 2;

   if (ADDR_BYTES % 2 != 0) begin : g_bad_bytes
      $error("ADDR_BYTES must be even");
   end
   if ((1 << PTR_W) < 2 * WORDS) begin : g_bad_ptr
      $error("PTR_W too narrow for the station words");
   end

   logic [PTR_W-1:0] ptr_q;
   ctrl_t            ctrl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (wr_en && wr_sel == SEL_PTR) begin
         ptr_q <= wr_data[PTR_W-1:0];
      end
   end

   for (genvar k = 0; k < WORDS; k++) begin : g_word
      logic [15:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (wr_en && wr_sel == SEL_DATA && ptr_q == PTR_W'(2 * k)) begin
            word_q <= wr_data[15:0];
         end
      end
      assign station[k*16 +: 16] = word_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en && wr_sel == SEL_CTRL) begin
         ctrl_q.en <= wr_data[CTRL_EN_BIT];
         if (!ctrl_q.en) begin
            ctrl_q.all_bc  <= wr_data[CTRL_BC_BIT];
            ctrl_q.all_mc  <= wr_data[CTRL_MC_BIT];
            ctrl_q.all_uc  <= wr_data[CTRL_UC_BIT];
            ctrl_q.perfect <= wr_data[CTRL_PM_BIT];
         end
      end
   end

   assign ctrl = ctrl_q;

   // R9
   class_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_CTRL && ctrl.en)
      |=> $stable({ctrl.all_bc, ctrl.all_mc, ctrl.all_uc, ctrl.perfect}));

   // R8
   odd_ptr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_DATA && ptr_q[0]) |=> $stable(station));
endmodule

// File: rtl/raf_classify.sv
module raf_classify
   import raf_pkg::*;
#(
   parameter int ADDR_BYTES = 6
) (
   input  logic [ADDR_BYTES*8-1:0] dst,
   input  logic [ADDR_BYTES*8-1:0] station,
   input  ctrl_t                   ctrl,
   output dcls_e                   cls,
   output logic                    accept
);
   logic [ADDR_BYTES-1:0] byte_eq;
   logic                  is_bc;
   logic                  is_mc;
   logic                  match;

   for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_cmp
      assign byte_eq[b] = (dst[b*8 +: 8] == station[b*8 +: 8]);
   end

   assign is_bc = &dst;
   assign is_mc = dst[0] && !is_bc;
   assign match = &byte_eq;

   always_comb begin
      if (is_bc)      cls = DCLS_BCAST;
      else if (is_mc) cls = DCLS_MULTI;
      else            cls = DCLS_UNI;
   end

   always_comb begin
      accept = 1'b0;
      if (ctrl.en) begin
         unique case (cls)
            DCLS_BCAST: accept = ctrl.all_bc;
            DCLS_MULTI: accept = ctrl.all_mc;
            default:    accept = ctrl.all_uc || (ctrl.perfect && match);
         endcase
      end
   end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import raf_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int PTR_W      = 8,
   parameter int REG_W      = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_wr,
   input  logic [1:0]              cfg_sel,
   input  logic [REG_W-1:0]        cfg_wdata,
   input  logic                    hdr_valid,
   input  logic [ADDR_BYTES*8-1:0] hdr_dst,
   output logic                    res_valid,
   output logic                    res_accept,
   output logic [1:0]              res_class
);
   localparam int DST_W = ADDR_BYTES * 8;

   if (REG_W <= CTRL_EN_BIT) begin : g_bad_regw
      $error("REG_W must hold the control bits");
   end

   logic [DST_W-1:0] station;
   ctrl_t            ctrl;
   dcls_e            cls_c;
   logic             acc_c;

   raf_cfg_regs #(
      .ADDR_BYTES (ADDR_BYTES),
      .PTR_W      (PTR_W),
      .REG_W      (REG_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr),
      .wr_sel  (cfg_sel),
      .wr_data (cfg_wdata),
      .station (station),
      .ctrl    (ctrl)
   );

   raf_classify #(
      .ADDR_BYTES (ADDR_BYTES)
   ) u_cls (
      .dst     (hdr_dst),
      .station (station),
      .ctrl    (ctrl),
      .cls     (cls_c),
      .accept  (acc_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_accept <= 1'b0;
         res_class  <= DCLS_RSVD;
      end else begin
         res_valid  <= hdr_valid;
         res_accept <= hdr_valid && acc_c;
         res_class  <= hdr_valid ? cls_c : DCLS_RSVD;
      end
   end

   // R2
   verdict_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |=> res_valid);

   // R2
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hdr_valid |=> !res_valid && !res_accept);

   // R5
   off_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && !ctrl.en) |=> !res_accept);

   // R3
   bcast_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && (&hdr_dst)) |=> res_class == DCLS_BCAST);

   // R4
   class_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> res_class != DCLS_RSVD);
endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_sel = 2'b00;
   logic [31:0] cfg_wdata = '0;
   logic        hdr_valid = 1'b0;
   logic [47:0] hdr_dst = '0;
   logic        res_valid;
   logic        res_accept;
   logic [1:0]  res_class;

   int checks = 0;
   int fails  = 0;

   logic [2:0] exp_q[$];
   string      tag_q[$];

   // bench model of the configuration, per the requirements
   logic [7:0]  m_ptr = '0;
   logic [15:0] m_word [3] = '{16'h0, 16'h0, 16'h0};
   logic        m_en = 0, m_bc = 0, m_mc = 0, m_uc = 0, m_pm = 0;

   always #5 clk = ~clk;

   rx_addr_filter u_rx_addr_filter (
      .clk (clk), .rst_n (rst_n), .cfg_wr (cfg_wr), .cfg_sel (cfg_sel),
      .cfg_wdata (cfg_wdata), .hdr_valid (hdr_valid), .hdr_dst (hdr_dst),
      .res_valid (res_valid), .res_accept (res_accept), .res_class (res_class)
   );

   function automatic logic [2:0] expect_of(input logic [47:0] d);
      logic [1:0] c;
      logic       a;
      logic [47:0] sta;
      sta = {m_word[2], m_word[1], m_word[0]};
      if (&d)       c = 2'b11;
      else if (d[0]) c = 2'b10;
      else          c = 2'b01;
      a = m_en && ((c == 2'b11 && m_bc) || (c == 2'b10 && m_mc) ||
                   (c == 2'b01 && (m_uc || (m_pm && d == sta))));
      return {a, c};
   endfunction

   function automatic void model_write(input logic [1:0] s, input logic [31:0] w);
      case (s)
         2'b00: m_ptr = w[7:0];
         2'b01: begin
            if (m_ptr == 8'd0) m_word[0] = w[15:0];
            if (m_ptr == 8'd2) m_word[1] = w[15:0];
            if (m_ptr == 8'd4) m_word[2] = w[15:0];
         end
         2'b10: begin
            if (!m_en) begin
               m_bc = w[30]; m_mc = w[29]; m_uc = w[28]; m_pm = w[27];
            end
            m_en = w[31];
         end
         default: ;
      endcase
   endfunction

   task automatic write_reg(input logic [1:0] s, input logic [31:0] w);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = w;
      model_write(s, w);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic send_hdr(input logic [47:0] d, input string tag);
      @(negedge clk);
      hdr_valid = 1'b1; hdr_dst = d;
      exp_q.push_back(expect_of(d));
      tag_q.push_back(tag);
      @(negedge clk);
      hdr_valid = 1'b0;
   endtask

   // header and configuration write in the same cycle
   task automatic send_with_write(input logic [47:0] d, input logic [1:0] s,
                                  input logic [31:0] w, input string tag);
      @(negedge clk);
      hdr_valid = 1'b1; hdr_dst = d;
      cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = w;
      exp_q.push_back(expect_of(d));
      tag_q.push_back(tag);
      model_write(s, w);
      @(negedge clk);
      hdr_valid = 1'b0; cfg_wr = 1'b0;
   endtask

   // monitor: pops expected verdicts as the design produces them
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R2: unexpected verdict acc=%0b cls=%b, expected none",
                     res_accept, res_class);
         end else begin
            logic [2:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if ({res_accept, res_class} !== e) begin
               fails++;
               $display("FAIL %s: acc=%0b cls=%b, expected acc=%0b cls=%b",
                        t, res_accept, res_class, e[2], e[1:0]);
            end
         end
      end
   end

   localparam logic [47:0] STA   = 48'h5544_3322_1102;
   localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
   localparam logic [47:0] MCAST = 48'h0000_0000_0001;
   localparam logic [47:0] UOTHR = 48'h5544_3322_1202;

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (res_valid !== 1'b0 || res_accept !== 1'b0) begin
         fails++;
         $display("FAIL R1: valid=%0b acc=%0b, expected 0 0", res_valid, res_accept);
      end
      rst_n = 1'b1;
      // R1: unconfigured block rejects everything
      send_hdr(BCAST, "R1");
      send_hdr(48'h0, "R1");
      // R5: class bits set but master enable off
      write_reg(2'b10, 32'h7800_0000);
      send_hdr(BCAST, "R5");
      send_hdr(MCAST, "R5");
      send_hdr(48'h0, "R5");
      write_reg(2'b10, 32'h0000_0000);
      // R8: station words, byte order and ignored offsets
      write_reg(2'b00, 32'd0); write_reg(2'b01, 32'h0000_1102);
      write_reg(2'b00, 32'd2); write_reg(2'b01, 32'h0000_3322);
      write_reg(2'b00, 32'd4); write_reg(2'b01, 32'h0000_5544);
      write_reg(2'b00, 32'd1); write_reg(2'b01, 32'h0000_FFFF);
      write_reg(2'b00, 32'd6); write_reg(2'b01, 32'h0000_FFFF);
      write_reg(2'b11, 32'hFFFF_FFFF);
      // R7: perfect match only
      write_reg(2'b10, 32'h8800_0000);
      send_hdr(48'h5544_3322_1100 | 48'h02, "R7");
      send_hdr(STA, "R8");
      send_hdr(UOTHR, "R7");
      send_hdr(48'hD544_3322_1102, "R7");
      send_hdr(BCAST, "R3");
      send_hdr(MCAST, "R4");
      send_hdr(48'h0102_0304_0503, "R4");
      send_hdr(48'hFFFF_FFFF_FFFE, "R4");
      // R9: class bits locked while enabled
      write_reg(2'b10, 32'hF000_0000);
      send_hdr(BCAST, "R9");
      send_hdr(UOTHR, "R9");
      send_hdr(STA, "R9");
      // R6: each accept-all enable alone
      write_reg(2'b10, 32'h0000_0000);
      write_reg(2'b10, 32'hC000_0000);
      send_hdr(BCAST, "R6"); send_hdr(MCAST, "R6"); send_hdr(STA, "R6");
      write_reg(2'b10, 32'h0000_0000);
      write_reg(2'b10, 32'hA000_0000);
      send_hdr(BCAST, "R6"); send_hdr(MCAST, "R6"); send_hdr(UOTHR, "R6");
      write_reg(2'b10, 32'h0000_0000);
      write_reg(2'b10, 32'h9000_0000);
      send_hdr(BCAST, "R6"); send_hdr(MCAST, "R6"); send_hdr(UOTHR, "R6");
      // R2: back-to-back headers
      write_reg(2'b10, 32'h0000_0000);
      write_reg(2'b10, 32'hF800_0000);
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         hdr_valid = 1'b1;
         hdr_dst = (i % 2 == 0) ? BCAST : UOTHR;
         exp_q.push_back(expect_of(hdr_dst));
         tag_q.push_back("R2");
         @(negedge clk);
      end
      hdr_valid = 1'b0;
      // R10: same-cycle write and header
      write_reg(2'b10, 32'h0000_0000);
      write_reg(2'b10, 32'h8800_0000);
      write_reg(2'b00, 32'd2);
      send_with_write(STA, 2'b01, 32'h0000_AAAA, "R10");
      send_hdr(STA, "R10");
      send_with_write(48'h5544_AAAA_1102, 2'b10, 32'h0000_0000, "R10");
      send_hdr(48'h5544_AAAA_1102, "R10");
      repeat (3) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R2: %0d verdicts missing, expected 0", exp_q.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R2: watchdog expired, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule